// File: doc/BRIEF.md
# Event-Capture Down-Counter

This block is a prescaled down-counter with two holding registers, built to time external events. A prescaler outside the block supplies a one-cycle tick, and the count drops by one on each tick. Two synchronized single-cycle event strobes (A and B) and a software start strobe are fed to a two-step sequencer. The sequencer sorts incoming strobes into the first event and the second event of a measurement pair. Selecting the same input for both events measures a period. Selecting A then B measures the phase between two signals. Edge detection and polarity choice are done upstream.

A mode input chooses between two measurement styles.

- **Free-running style:** the counter wraps from zero to all-ones. The first event copies the live count into the reload/capture register, and the second event copies it into the capture register. Software reads the difference between the two values.
- **Reload style:** the first event restarts the counter from the reload/capture register, and the second event copies the count into the capture register. While this style is selected, events never overwrite the reload/capture register. When the counter reaches zero it reloads from that register. In both styles a one-cycle overflow strobe marks each wrap or reload caused by a tick. A small write port lets software load either holding register.

Reset is asynchronous and active-low, and is expected to be released in step with the clock.

Top module: `evcap_counter`

## Requirements
- R1: After reset the count, both holding registers and the overflow strobe are all zero, and the sequencer waits for a first event.
- R2: The count decreases by one on each clock edge where `tick_i` is high and the count is non-zero. With no tick and no event reload, the count holds its value.
- R3: In free-running style (`reload_mode_i`=0), a tick at count zero sets the count to all-ones. `ovf_o` is then high for exactly the one following cycle, and it is never high without such a wrap or reload.
- R4: In reload style (`reload_mode_i`=1), a tick at count zero loads the count from the reload/capture register and pulses `ovf_o`. After the count is loaded with value V, the overflow appears on tick number V+1.
- R5: The first-event source is chosen by `start_sel_i`: 00 selects A, 01 selects B, and 10 or 11 select the software strobe. The second-event source is chosen by `stop_sel_i`: 0 selects A, 1 selects B. A strobe from a source that is not selected for the current step has no effect.
- R6: In free-running style, the first event stores the live count into `reload_o`, and the next second event stores the live count into `capture_o`. The sequencer then waits for a first event again.
- R7: In reload style, the first event loads the count from `reload_o`, and this takes priority over a tick in the same cycle (no overflow is signalled for that cycle). The next second event stores the live count into `capture_o`.
- R8: While `reload_mode_i` is 1, events never change `reload_o`. Only a write can change it.
- R9: A write with `wr_addr_i`=0 loads `reload_o`, and a write with `wr_addr_i`=1 loads `capture_o`, both on the next edge. If a capture targets the same register in the same cycle, the capture value wins.
- R10: A captured value equals `count_o` as seen in the cycle of the event, before any tick in that cycle takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Prescaler tick, one cycle wide |
| ev_a_i | input | 1 | Event strobe A |
| ev_b_i | input | 1 | Event strobe B |
| sw_start_i | input | 1 | Software run/restart strobe |
| reload_mode_i | input | 1 | 0 = free-running style, 1 = reload style |
| start_sel_i | input | 2 | First-event source select |
| stop_sel_i | input | 1 | Second-event source select |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 1 | 0 = reload/capture register, 1 = capture register |
| wr_data_i | input | W | Write data |
| count_o | output | W | Live count |
| reload_o | output | W | Reload/capture register |
| capture_o | output | W | Capture register |
| ovf_o | output | 1 | Overflow strobe, one cycle |

## Verification
Every result is due one edge after its cause: a strobe, tick or write sampled at edge N shows on `count_o`, `reload_o`, `capture_o` or `ovf_o` after edge N. This is why overflow is seen in the cycle after the tick that found the count at zero. The bench drives each input set on a falling edge and compares outputs on the next falling edge. At that point it also compares against an arithmetic reference that it advances once per cycle. The directed sweeps count ticks up to the overflow, expecting V+1, and check the captured interval, expecting start minus ticks modulo 2^W, at that same one-edge offset.

// File: rtl/evcap_pkg.sv
package evcap_pkg;
  typedef enum logic {
    SEQ_FIRST  = 1'b0,
    SEQ_SECOND = 1'b1
  } seq_e;

  localparam logic [1:0] START_A = 2'b00;
  localparam logic [1:0] START_B = 2'b01;
  localparam int SLOT_RELOAD  = 0;
  localparam int SLOT_CAPTURE = 1;
  localparam int NUM_SLOTS    = 2;
endpackage

// File: rtl/evcap_seq.sv
module evcap_seq
  import evcap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_a_i,
  input  logic       ev_b_i,
  input  logic       sw_start_i,
  input  logic [1:0] start_sel_i,
  input  logic       stop_sel_i,
  output logic       first_hit_o,
  output logic       second_hit_o
);
  seq_e state_q, state_d;
  logic first_src, second_src;

  always_comb begin
    case (start_sel_i)
      START_A: first_src = ev_a_i;
      START_B: first_src = ev_b_i;
      default: first_src = sw_start_i;
    endcase
    second_src = stop_sel_i ? ev_b_i : ev_a_i;
  end

  assign first_hit_o  = (state_q == SEQ_FIRST)  && first_src;
  assign second_hit_o = (state_q == SEQ_SECOND) && second_src;

  always_comb begin
    state_d = state_q;
    if (first_hit_o)       state_d = SEQ_SECOND;
    else if (second_hit_o) state_d = SEQ_FIRST;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_FIRST;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/evcap_count.sv
module evcap_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic         wrap_load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] count_o,
  output logic         ovf_o
);
  logic [W-1:0] count_q, count_d;
  logic         cnt_en, at_zero, roll, ovf_q;

  assign at_zero = (count_q == '0);
  assign roll    = tick_i && at_zero && !load_i;
  assign cnt_en  = load_i || tick_i;

  always_comb begin
    if (load_i)           count_d = load_val_i;
    else if (at_zero)     count_d = wrap_load_i ? load_val_i : {W{1'b1}};
    else                  count_d = count_q - {{(W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_q <= '0;
    else if (cnt_en) count_q <= count_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= roll;
  end

  assign count_o = count_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/evcap_regs.sv
module evcap_regs #(
  parameter int W  = 16,
  parameter int N  = 2,
  localparam int AW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        cap_hit_i,
  input  logic [W-1:0]        cap_val_i,
  input  logic                wr_en_i,
  input  logic [AW-1:0]       wr_addr_i,
  input  logic [W-1:0]        wr_data_i,
  output logic [N-1:0][W-1:0] slot_o
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    logic         wr_hit, en;
    logic [W-1:0] d, q;

    assign wr_hit = wr_en_i && (wr_addr_i == AW'(g));
    assign en     = cap_hit_i[g] || wr_hit;
    assign d      = cap_hit_i[g] ? cap_val_i : wr_data_i;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign slot_o[g] = q;
  end
endmodule

// File: rtl/evcap_counter.sv
module evcap_counter
  import evcap_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         ev_a_i,
  input  logic         ev_b_i,
  input  logic         sw_start_i,
  input  logic         reload_mode_i,
  input  logic [1:0]   start_sel_i,
  input  logic         stop_sel_i,
  input  logic         wr_en_i,
  input  logic         wr_addr_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] count_o,
  output logic [W-1:0] reload_o,
  output logic [W-1:0] capture_o,
  output logic         ovf_o
);
  logic                        first_hit, second_hit;
  logic [NUM_SLOTS-1:0]        cap_hit;
  logic [NUM_SLOTS-1:0][W-1:0] slots;
  logic [W-1:0]                count;

  evcap_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_a_i       (ev_a_i),
    .ev_b_i       (ev_b_i),
    .sw_start_i   (sw_start_i),
    .start_sel_i  (start_sel_i),
    .stop_sel_i   (stop_sel_i),
    .first_hit_o  (first_hit),
    .second_hit_o (second_hit)
  );

  // Slot 0 is blocked from event capture while reload style is active.
  assign cap_hit[SLOT_RELOAD]  = first_hit && !reload_mode_i;
  assign cap_hit[SLOT_CAPTURE] = second_hit;

  evcap_count #(.W(W)) u_count (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .load_i      (first_hit && reload_mode_i),
    .wrap_load_i (reload_mode_i),
    .load_val_i  (slots[SLOT_RELOAD]),
    .count_o     (count),
    .ovf_o       (ovf_o)
  );

  evcap_regs #(.W(W), .N(NUM_SLOTS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_hit_i (cap_hit),
    .cap_val_i (count),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .slot_o    (slots)
  );

  assign count_o   = count;
  assign reload_o  = slots[SLOT_RELOAD];
  assign capture_o = slots[SLOT_CAPTURE];
endmodule

// File: rtl/evcap_counter_chk.sv
module evcap_counter_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick_i,
  input logic         reload_mode_i,
  input logic         wr_en_i,
  input logic         wr_addr_i,
  input logic [W-1:0] count_o,
  input logic [W-1:0] reload_o,
  input logic [W-1:0] capture_o,
  input logic         ovf_o,
  input logic         first_hit,
  input logic         second_hit
);
  a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && count_o != '0 && !(first_hit && reload_mode_i))
      |=> count_o == ($past(count_o) - W'(1)));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !(first_hit && reload_mode_i)) |=> $stable(count_o));

  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && count_o == '0 && !reload_mode_i) |=> (count_o == {W{1'b1}} && ovf_o));

  a_r3_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> $past(tick_i && count_o == '0 && !(first_hit && reload_mode_i)));

  a_r4_zero_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && count_o == '0 && reload_mode_i && !first_hit)
      |=> (count_o == $past(reload_o) && ovf_o));

  a_r5_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({first_hit, second_hit}));

  a_r6_free_store: assert property (@(posedge clk) disable iff (!rst_n)
    (first_hit && !reload_mode_i) |=> reload_o == $past(count_o));

  a_r7_event_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (first_hit && reload_mode_i) |=> (count_o == $past(reload_o) && !ovf_o));

  a_r10_capture: assert property (@(posedge clk) disable iff (!rst_n)
    second_hit |=> capture_o == $past(count_o));

  a_r8_reload_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_mode_i && !(wr_en_i && !wr_addr_i)) |=> $stable(reload_o));

  a_r9_cap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!second_hit && !(wr_en_i && wr_addr_i)) |=> $stable(capture_o));
endmodule

bind evcap_counter evcap_counter_chk #(.W(W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tick_i        (tick_i),
  .reload_mode_i (reload_mode_i),
  .wr_en_i       (wr_en_i),
  .wr_addr_i     (wr_addr_i),
  .count_o       (count_o),
  .reload_o      (reload_o),
  .capture_o     (capture_o),
  .ovf_o         (ovf_o),
  .first_hit     (first_hit),
  .second_hit    (second_hit)
);

// File: tb/evcap_counter_bench.sv
`timescale 1ns/1ps
module evcap_counter_bench;
  localparam int W = 8;
  localparam int M = 1 << W;

  logic         clk, rst_n, tick_i, ev_a_i, ev_b_i, sw_start_i;
  logic         reload_mode_i, stop_sel_i, wr_en_i, wr_addr_i, ovf_o;
  logic [1:0]   start_sel_i;
  logic [W-1:0] wr_data_i, count_o, reload_o, capture_o;

  int errs = 0, checks = 0;
  int m_cnt, m_rel, m_cap, m_ovf, m_state;
  bit done = 0;

  evcap_counter #(.W(W)) u_evcap_counter (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Called on a falling edge; returns on the next falling edge after comparing.
  task automatic cyc(int a = 0, int b = 0, int sw = 0, int tk = 0,
                     int we = 0, int wa = 0, int wd = 0);
    int fsrc, ssrc, fh, sh, nc, nr, ncap, no;
    ev_a_i = a[0]; ev_b_i = b[0]; sw_start_i = sw[0]; tick_i = tk[0];
    wr_en_i = we[0]; wr_addr_i = wa[0]; wr_data_i = W'(wd);
    fsrc = (start_sel_i == 2'd0) ? a : (start_sel_i == 2'd1) ? b : sw;
    ssrc = stop_sel_i ? b : a;
    fh = (m_state == 0 && fsrc != 0) ? 1 : 0;
    sh = (m_state == 1 && ssrc != 0) ? 1 : 0;
    nc = m_cnt; nr = m_rel; ncap = m_cap; no = 0;
    if (fh != 0 && reload_mode_i) nc = m_rel;
    else if (tk != 0) begin
      if (m_cnt == 0) begin nc = reload_mode_i ? m_rel : M - 1; no = 1; end
      else nc = m_cnt - 1;
    end
    if (fh != 0 && !reload_mode_i) nr = m_cnt;
    else if (we != 0 && wa == 0) nr = wd % M;
    if (sh != 0) ncap = m_cnt;
    else if (we != 0 && wa != 0) ncap = wd % M;
    if (fh != 0) m_state = 1; else if (sh != 0) m_state = 0;
    @(negedge clk);
    m_cnt = nc; m_rel = nr; m_cap = ncap; m_ovf = no;
    ev_a_i = 0; ev_b_i = 0; sw_start_i = 0; tick_i = 0; wr_en_i = 0;
    chk("R2 count", int'(count_o), m_cnt);
    chk("R3 ovf", int'(ovf_o), m_ovf);
    chk("R8 reload reg", int'(reload_o), m_rel);
    chk("R6 capture reg", int'(capture_o), m_cap);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; tick_i = 0; ev_a_i = 0; ev_b_i = 0; sw_start_i = 0;
    reload_mode_i = 0; start_sel_i = 0; stop_sel_i = 0;
    wr_en_i = 0; wr_addr_i = 0; wr_data_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    m_cnt = 0; m_rel = 0; m_cap = 0; m_ovf = 0; m_state = 0;
    chk("R1 reset count", int'(count_o), 0);
    chk("R1 reset reload", int'(reload_o), 0);
    chk("R1 reset capture", int'(capture_o), 0);
    chk("R1 reset ovf", int'(ovf_o), 0);

    // R3: free-running wrap from zero
    cyc(.tk(1));
    chk("R3 wrap to all-ones", int'(count_o), M - 1);
    chk("R3 ovf pulse", int'(ovf_o), 1);
    cyc();
    chk("R3 ovf one cycle", int'(ovf_o), 0);

    // R4 / R7: reload-style period sweep over every reload value
    reload_mode_i = 1; start_sel_i = 2'd2; stop_sel_i = 0;
    for (int r = 0; r < M; r++) begin
      int n;
      cyc(.we(1), .wa(0), .wd(r));
      cyc(.sw(1), .tk(r % 2));
      chk("R7 event reload wins over tick", int'(count_o), r);
      n = 0;
      do begin cyc(.tk(1)); n++; end while (!ovf_o && n < M + 2);
      chk("R4 overflow on tick V+1", n, r + 1);
      chk("R4 reload at zero", int'(count_o), r);
      cyc(.a(1));
      chk("R7 second event captures", int'(capture_o), r);
      chk("R8 reload kept in reload style", int'(reload_o), r);
    end

    // R6 / R10 / R2: free-running period measurement, ticks spread over idle cycles
    reload_mode_i = 0; start_sel_i = 2'd0; stop_sel_i = 0;
    for (int n = 0; n < 300; n += 7) begin
      int c0;
      cyc(.a(1));
      c0 = int'(reload_o);
      for (int k = 0; k < 2 * n; k++) cyc(.tk(k % 2));
      cyc(.a(1), .tk(1));
      chk("R6 R10 period capture", int'(capture_o), ((c0 - n) % M + M) % M);
    end

    // R5 / R10: phase A->B, with A ignored while waiting for B
    stop_sel_i = 1;
    cyc(.a(1));
    for (int k = 0; k < 5; k++) cyc(.tk(1));
    begin
      int capk;
      capk = int'(capture_o);
      cyc(.a(1), .tk(1));
      chk("R5 unselected second source ignored", int'(capture_o), capk);
    end
    cyc(.b(1));
    chk("R5 phase capture", int'(capture_o), ((int'(reload_o) - 6) % M + M) % M);

    // R5: exhaustive source sweep for the first event
    for (int sel = 0; sel < 4; sel++) begin
      for (int stp = 0; stp < 2; stp++) begin
        for (int combo = 0; combo < 8; combo++) begin
          int c, fired;
          start_sel_i = 2'(sel); stop_sel_i = stp[0];
          c = int'(count_o);
          cyc(.we(1), .wa(0), .wd((c + 7) % M));
          cyc(.a(combo & 1), .b((combo >> 1) & 1), .sw((combo >> 2) & 1));
          fired = (sel == 0) ? (combo & 1) : (sel == 1) ? ((combo >> 1) & 1) : ((combo >> 2) & 1);
          chk("R5 first-source select", int'(reload_o), (fired != 0) ? c : (c + 7) % M);
          if (fired != 0) begin
            cyc(.tk(1));
            cyc(.a(stp == 0), .b(stp == 1));
            chk("R5 second-source select", int'(capture_o), (c + M - 1) % M);
          end
        end
      end
    end

    // R9: write port and capture priority
    start_sel_i = 2'd0; stop_sel_i = 0;
    cyc(.tk(1));
    cyc(.a(1), .we(1), .wa(0), .wd(200));
    chk("R9 capture beats write (reload)", int'(reload_o), int'(count_o));
    cyc(.a(1), .we(1), .wa(1), .wd(201));
    chk("R9 capture beats write (capture)", int'(capture_o), int'(count_o));
    cyc(.we(1), .wa(1), .wd(77));
    chk("R9 write capture reg", int'(capture_o), 77);
    cyc(.we(1), .wa(0), .wd(55));
    chk("R9 write reload reg", int'(reload_o), 55);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule